// File: doc/BRIEF.md
# Goldschmidt mantissa square root unit

This block computes the truncated square root of a normalized floating-point significand. The significand arrives with an implied leading one and 54 fraction bits, together with a flag saying whether the exponent was odd. When the flag is set, the operand is doubled so that it always lies in [1.0, 4.0) and the exponent can be halved exactly. The root comes back as an unsigned fixed-point number with 10 integer bits and 54 fraction bits. A flag reports whether any remainder was left, so that a later rounding stage can treat the result as inexact.

The operand's leading bits select a seed for the reciprocal square root from a 768-entry table. The table contents are computed at elaboration. Three Goldschmidt passes then refine a root estimate and a half-reciprocal-root estimate together. A residual (operand minus root squared) is multiplied by the reciprocal estimate, and an 8-bit signed slice of that product adjusts the root. A final loop compares the exact remainder with 2R+1 and with zero, and steps the root by one unit until it is the exact floor. One signed multiplier is shared by every step, and a small state machine sequences the work, one product per cycle. A caller pulses start while the unit is idle, then waits for the one-cycle done pulse.

Top module: `gsqrt_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, inexact_o and every bit of root_o are 0.
- R2: A start_i pulse while busy_o is 0 makes busy_o 1 in the next cycle. Completion is marked by done_o being 1 for exactly one cycle, and busy_o is 0 in that cycle.
- R3: With odd_exp_i = 0, root_o equals floor(sqrt(sig_i * 2^54)) as an unsigned integer. Here sig_i is read as an integer with bit 54 set, so the value is 1.54 fixed point. Bits 63:54 of root_o therefore hold 1.
- R4: inexact_o is 1 exactly when root_o squared differs from the operand scaled by 2^54, that is, when the remainder is non-zero.
- R5: A start_i pulse while busy_o is 1 is ignored: the running operation finishes with the result of the operand it accepted.
- R6: With odd_exp_i = 1, the operand is doubled before the root is taken: root_o equals floor(sqrt(sig_i * 2^55)).
- R7: The seed table has 768 entries, indexed by bits 55:46 of the doubled-range operand minus 256. Each seed lies in [0.5, 1.0] in 1.12 format (2048 to 4096). An operand drawn from any of the 768 regions returns the exact result.
- R8: root_o and inexact_o keep their values from one done_o pulse until the next.
- R9: The extreme operands are exact: 1.0, the largest value just below 4.0, and a fraction with only its lowest bit set. Operands that are perfect squares (1.0, 1.5625, 2.25) give inexact_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation (accepted only while idle) |
| sig_i | input | 55 | Significand, 1.54 fixed point, bit 54 set |
| odd_exp_i | input | 1 | 1 = operand is doubled before the root is taken |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| root_o | output | 64 | Root, 10.54 fixed point |
| inexact_o | output | 1 | Non-zero remainder |

## Verification
The hardest thing to reach from the ports is the final correction loop taking its decrement branch or stepping more than once. This depends on how the seed error and the truncation in the refinement steps happen to fall for a particular operand. The bench therefore sweeps all 768 seed regions with random low-order bits, so every seed entry and the full spread of leftover errors are exercised. Exact squares and the extreme operands are placed in a table, because they exercise the path where the remainder is exactly zero.

// File: rtl/gsqrt_pkg.sv
package gsqrt_pkg;

    localparam int FRAC_BITS = 54;
    localparam int INT_BITS  = 10;
    localparam int ROOT_W    = INT_BITS + FRAC_BITS;
    localparam int SIG_W     = FRAC_BITS + 1;
    localparam int OPND_W    = FRAC_BITS + 2;
    localparam int MUL_W     = FRAC_BITS + 4;
    localparam int PROD_W    = 2 * MUL_W;
    localparam int SEED_FRAC = 12;
    localparam int SEED_W    = SEED_FRAC + 1;
    localparam int IDX_FRAC  = 8;
    localparam int IDX_W     = IDX_FRAC + 2;
    localparam int ROM_DEPTH = 3 << IDX_FRAC;
    localparam int GS_ITERS  = 3;

    typedef logic signed [MUL_W-1:0]  fix_t;
    typedef logic signed [PROD_W-1:0] wide_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SEED, S_GH, S_G, S_H, S_SQ, S_CORR, S_CHK
    } sq_state_e;

    // Seed = 1/sqrt(region midpoint) in 1.SEED_FRAC format.
    // Midpoint = (2*(2^IF + idx) + 1) / 2^(IF+1).
    function automatic logic [SEED_W-1:0] seed_calc(input int unsigned idx,
                                                    input int unsigned idx_frac,
                                                    input int unsigned seed_frac);
        logic [63:0] num;
        logic [63:0] q;
        logic [63:0] val;
        logic [63:0] res;
        logic [63:0] trial;
        q   = 64'(2 * ((1 << idx_frac) + idx) + 1);
        num = 64'd1 << (idx_frac + 1 + 2 * seed_frac);
        val = num / q;
        res = '0;
        for (int b = SEED_W - 1; b >= 0; b--) begin
            trial = res | (64'd1 << b);
            if (trial * trial <= val) res = trial;
        end
        return res[SEED_W-1:0];
    endfunction

endpackage

// File: rtl/gsqrt_seed_rom.sv
module gsqrt_seed_rom
    import gsqrt_pkg::*;
#(
    parameter int IF_BITS = IDX_FRAC,
    parameter int SF_BITS = SEED_FRAC
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [SEED_W-1:0] seed_o
);
    localparam int DEPTH = 3 << IF_BITS;

    logic [SEED_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = seed_calc(i, IF_BITS, SF_BITS);
    end

    assign seed_o = (int'(idx_i) < DEPTH) ? table_q[idx_i] : '0;

endmodule

// File: rtl/gsqrt_mul.sv
module gsqrt_mul #(
    parameter int W = 58
) (
    input  logic signed [W-1:0]   a_i,
    input  logic signed [W-1:0]   b_i,
    output logic signed [2*W-1:0] p_o
);
    assign p_o = a_i * b_i;
endmodule

// File: rtl/gsqrt_unit.sv
module gsqrt_unit
    import gsqrt_pkg::*;
#(
    parameter int ITERS = GS_ITERS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SIG_W-1:0]  sig_i,
    input  logic              odd_exp_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ROOT_W-1:0] root_o,
    output logic              inexact_o
);
    localparam int   IT_W     = $clog2(ITERS + 1);
    localparam int   SEED_PAD = MUL_W - SEED_W - FRAC_BITS + SEED_FRAC;
    localparam fix_t HALF     = fix_t'(1) <<< (FRAC_BITS - 1);

    sq_state_e         state_q;
    logic [IT_W-1:0]   iter_q;
    logic [OPND_W-1:0] xop_q;
    fix_t              g_q, h_q, r_q, rt_q;
    wide_t             dres_q;
    logic [ROOT_W-1:0] root_q;
    logic              inex_q, done_q;

    logic [IDX_W-1:0]  rom_idx;
    logic [SEED_W-1:0] seed;
    fix_t              mul_a, mul_b, prod_fix, corr_fix, seed_fix, opnd_fix;
    wide_t             prod, prod_sh, corr_sh, n_wide, d_wide, two_r1;
    logic [7:0]        corr8;

    assign rom_idx = xop_q[OPND_W-1 -: IDX_W] - IDX_W'(1 << IDX_FRAC);

    gsqrt_seed_rom u_rom (.idx_i(rom_idx), .seed_o(seed));

    gsqrt_mul #(.W(MUL_W)) u_mul (.a_i(mul_a), .b_i(mul_b), .p_o(prod));

    assign opnd_fix = $signed({{(MUL_W-OPND_W){1'b0}}, xop_q});
    assign seed_fix = $signed({{SEED_PAD{1'b0}}, seed, {(FRAC_BITS-SEED_FRAC){1'b0}}});
    assign prod_sh  = prod >>> FRAC_BITS;
    assign prod_fix = prod_sh[MUL_W-1:0];
    assign corr_sh  = prod >>> (2 * FRAC_BITS - 2);
    assign corr8    = corr_sh[7:0];
    assign corr_fix = $signed({{(MUL_W-8){corr8[7]}}, corr8}) >>> 2;
    assign n_wide   = $signed({{(PROD_W-OPND_W-FRAC_BITS){1'b0}}, xop_q, {FRAC_BITS{1'b0}}});
    assign d_wide   = n_wide - prod;
    assign two_r1   = $signed({{(PROD_W-MUL_W-1){rt_q[MUL_W-1]}}, rt_q, 1'b1});

    logic unused_bits;
    assign unused_bits = ^{prod_sh[PROD_W-1:MUL_W], corr_sh[PROD_W-1:8],
                           rt_q[MUL_W-1:SIG_W]};

    // One product per cycle; the state picks the operands.
    always_comb begin
        mul_a = g_q;
        mul_b = h_q;
        unique case (state_q)
            S_SEED:  begin mul_a = opnd_fix;             mul_b = seed_fix; end
            S_GH:    begin mul_a = g_q;                  mul_b = h_q;      end
            S_G:     begin mul_a = g_q;                  mul_b = r_q;      end
            S_H:     begin mul_a = h_q;                  mul_b = r_q;      end
            S_SQ:    begin mul_a = g_q;                  mul_b = g_q;      end
            S_CORR:  begin mul_a = dres_q[MUL_W-1:0];    mul_b = h_q;      end
            S_CHK:   begin mul_a = rt_q;                 mul_b = rt_q;     end
            default: begin mul_a = g_q;                  mul_b = h_q;      end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            iter_q  <= '0;
            xop_q   <= '0;
            g_q     <= '0;
            h_q     <= '0;
            r_q     <= '0;
            rt_q    <= '0;
            dres_q  <= '0;
            root_q  <= '0;
            inex_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    xop_q   <= odd_exp_i ? {sig_i, 1'b0} : {1'b0, sig_i};
                    state_q <= S_SEED;
                end
                S_SEED: begin
                    g_q     <= prod_fix;
                    h_q     <= seed_fix >>> 1;
                    iter_q  <= '0;
                    state_q <= S_GH;
                end
                S_GH: begin
                    r_q     <= HALF - prod_fix;
                    state_q <= S_G;
                end
                S_G: begin
                    g_q     <= g_q + prod_fix;
                    state_q <= S_H;
                end
                S_H: begin
                    h_q     <= h_q + prod_fix;
                    iter_q  <= iter_q + 1'b1;
                    state_q <= (int'(iter_q) == ITERS - 1) ? S_SQ : S_GH;
                end
                S_SQ: begin
                    dres_q  <= d_wide;
                    state_q <= S_CORR;
                end
                S_CORR: begin
                    rt_q    <= g_q + corr_fix;
                    state_q <= S_CHK;
                end
                S_CHK: begin
                    if (d_wide[PROD_W-1]) begin
                        rt_q <= rt_q - fix_t'(1);
                    end else if (d_wide >= two_r1) begin
                        rt_q <= rt_q + fix_t'(1);
                    end else begin
                        root_q  <= {{(ROOT_W-SIG_W){1'b0}}, rt_q[SIG_W-1:0]};
                        inex_q  <= (d_wide != '0);
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign root_o    = root_q;
    assign inexact_o = inex_q;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);                                  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                               // R2
    AST_ROOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(root_o) && $stable(inexact_o)));              // R8
    AST_ROOT_UNIT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (root_o[ROOT_W-1:FRAC_BITS] == INT_BITS'(1)));          // R3
    AST_SEED_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SEED) |-> (seed >= SEED_W'(1 << (SEED_FRAC-1))
                                 && seed <= SEED_W'(1 << SEED_FRAC)));     // R7

endmodule

// File: tb/gsqrt_unit_bench.sv
module gsqrt_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [54:0] sig_in = '0;
    logic        odd_in = 1'b0;
    logic        busy, done, inexact;
    logic [63:0] root;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    gsqrt_unit u_gsqrt_unit (
        .clk(clk), .rst(rst), .start_i(start), .sig_i(sig_in),
        .odd_exp_i(odd_in), .busy_o(busy), .done_o(done),
        .root_o(root), .inexact_o(inexact)
    );

    // {odd flag, significand}; 1.0 = bit 54 set
    localparam logic [55:0] VECS [12] = '{
        {1'b0, 1'b1, 54'h00000000000000},
        {1'b1, 1'b1, 54'h00000000000000},
        {1'b0, 1'b1, 54'h24000000000000},
        {1'b1, 1'b1, 54'h08000000000000},
        {1'b0, 1'b1, 54'h3FFFFFFFFFFFFF},
        {1'b1, 1'b1, 54'h3FFFFFFFFFFFFF},
        {1'b0, 1'b1, 54'h00000000000001},
        {1'b1, 1'b1, 54'h00000000000001},
        {1'b0, 1'b1, 54'h20000000000000},
        {1'b1, 1'b1, 54'h15555555555555},
        {1'b0, 1'b1, 54'h3D70A3D70A3D70},
        {1'b1, 1'b1, 54'h2AAAAAAAAAAAAA}
    };

    logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

    function automatic logic [63:0] isqrt(input logic [127:0] n);
        logic [63:0]  res;
        logic [127:0] t;
        res = '0;
        for (int b = 63; b >= 0; b--) begin
            t = 128'(res | (64'd1 << b));
            if (t * t <= n) res = t[63:0];
        end
        return res;
    endfunction

    task automatic step_rng();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
    endtask

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic odd, input logic [54:0] sig,
                          input string req, input logic busy_start);
        logic [127:0] n;
        logic [63:0]  er;
        logic         ei;
        int           w;
        n  = odd ? (128'(sig) << 55) : (128'(sig) << 54);
        er = isqrt(n);
        ei = ((128'(er) * 128'(er)) != n);
        @(negedge clk);
        start = 1'b1; sig_in = sig; odd_in = odd;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        if (busy_start) begin
            // R5: second start with a different operand while busy
            sig_in = ~sig | (55'd1 << 54); odd_in = ~odd;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, "R2 done pulse", 64'(done), 64'd1);
        chk(busy == 1'b0, "R2 busy low at done", 64'(busy), 64'd0);
        chk(root == er, req, root, er);
        chk(inexact == ei, "R4 inexact", 64'(inexact), 64'(ei));
        @(negedge clk);
        chk(done == 1'b0, "R2 single-cycle done", 64'(done), 64'd0);
        chk(root == er, "R8 root held", root, er);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0,    "R1 busy",    64'(busy), 64'd0);
        chk(done == 1'b0,    "R1 done",    64'(done), 64'd0);
        chk(root == 64'd0,   "R1 root",    root, 64'd0);
        chk(inexact == 1'b0, "R1 inexact", 64'(inexact), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && root == 64'd0, "R1 after release",
            {busy, done, root[61:0]}, 64'd0);

        // Table: boundaries (R9), even (R3) and odd (R6) operands
        foreach (VECS[i]) begin
            run_op(VECS[i][55], VECS[i][54:0],
                   VECS[i][55] ? "R6 R9 root odd table" : "R3 R9 root even table", 1'b0);
        end

        // R9: exact squares must report no remainder
        run_op(1'b0, {1'b1, 54'h24000000000000}, "R9 root 1.5625", 1'b0);
        chk(inexact == 1'b0, "R9 exact 1.5625", 64'(inexact), 64'd0);
        run_op(1'b1, {1'b1, 54'h08000000000000}, "R9 root 2.25", 1'b0);
        chk(inexact == 1'b0, "R9 exact 2.25", 64'(inexact), 64'd0);
        chk(root == 64'h0060000000000000, "R9 root value 1.5", root, 64'h0060000000000000);

        // R5: start while busy is ignored
        run_op(1'b0, {1'b1, 54'h1234567890ABCD}, "R5 result of first operand", 1'b1);

        // R8: outputs hold while idle
        begin
            logic [63:0] held_r;
            logic        held_i;
            held_r = root; held_i = inexact;
            repeat (20) @(negedge clk);
            chk(root == held_r, "R8 root idle hold", root, held_r);
            chk(inexact == held_i, "R8 inexact idle hold", 64'(inexact), 64'(held_i));
        end

        // Random operands, both parities (R3, R6)
        for (int k = 0; k < 60; k++) begin
            step_rng();
            run_op(lfsr[63], {1'b1, lfsr[53:0]},
                   lfsr[63] ? "R6 root random odd" : "R3 root random even", 1'b0);
        end

        // R7: one operand from every seed region
        for (int i = 0; i < 768; i++) begin
            logic [55:0] x;
            step_rng();
            x = (56'(256 + i) << 46) | 56'(lfsr[45:0]);
            if (x[55]) begin
                x[0] = 1'b0;
                run_op(1'b1, x[55:1], "R7 seed region odd", 1'b0);
            end else begin
                run_op(1'b0, x[54:0], "R7 seed region even", 1'b0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule